// File: doc/BRIEF.md
# Cascadable Dual Countdown Timer

This block provides two 16-bit down-counters that share one free-running tick prescaler. The prescaler divides the system clock down to a 10 µs tick. Each running counter decrements once per tick. When its period is complete it reloads its initial value, sets a sticky overrun status bit and, if enabled, drives a level interrupt. A cascade bit joins the two counters into a single 32-bit counter. Counter 0 is the low half, and only the first status bit and interrupt are used in that mode.

Software reaches the block through a byte-wide register port. Writes take effect at the clock edge, and read data is combinational from the address. The map holds a control byte, a write-one-to-clear byte, a status byte, four initial-value bytes and four live count bytes. The initial-value and count bytes are laid out as low and high bytes of counter 0, then of counter 1. A control value of zero stops both counters but leaves the status bits alone.

Top module: `cascade_timer`

## Requirements
- R1: The prescaler emits one tick every CLK_HZ/TICK_HZ clock cycles. It runs freely from reset and is never restarted by the control register, so the first period after enabling may be short by up to one tick.
- R2: In independent mode (control bit 2 = 0), a counter whose run bit is set (bit 0 for counter 0, bit 1 for counter 1) behaves as follows on each tick. It decrements by one, or it reloads its initial value and records an expiry when its value is 1 or 0. The period is therefore the initial value in ticks.
- R3: A counter whose run bit is clear continuously reloads its initial value, so its count bytes read back the initial value.
- R4: In cascade mode (control bit 2 = 1), run bit 0 controls one 32-bit counter {counter 1, counter 0}. It decrements with borrow from the low half into the high half. It reloads {initial 1, initial 0} at a value of 1 or 0 and records expiry only on status bit 0. Interrupt 1 is held low in this mode.
- R5: An expiry of counter n sets status bit n at address 2 (bits 7..2 read 0). Writing 1 to bit n of the clear register at address 1 clears it. When an expiry and a clear land in the same cycle, the set wins.
- R6: Writing 0 to the control register stops the counters and drives both interrupts low, without clearing any status bit.
- R7: irq0 is high while status bit 0 and control bit 3 are both set. irq1 is high while status bit 1 and control bit 4 are both set and cascade is off.
- R8: The register map is as follows. Address 0 is control (it reads back the written byte). Address 1 is clear (it reads 0). Addresses 3, 4, 5 and 6 hold the initial values: counter 0 low and high, then counter 1 low and high. Addresses 7, 8, 9 and 10 return the live counts in the same byte order. Addresses 11 to 15 read 0.
- R9: After reset every register and count reads 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for addr, combinational |
| irq0 | output | 1 | Level interrupt of counter 0, or of the 32-bit counter |
| irq1 | output | 1 | Level interrupt of counter 1 |

## Verification
A write presented before a clock edge is visible on rdata from that edge onward. A counter changes on the edge where the tick is high. Its status bit and interrupt follow on that same edge, because the interrupt is a combinational function of registered status and control. The bench advances a reference model on every rising edge from the same inputs the design sampled. It drives inputs and compares rdata and both interrupts only after the falling edge, so each result is checked a half cycle after the edge that produced it. The tick spacing is measured directly as the gap in cycles between two changes of a live count byte.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NBYTES = 2 * CNT_W / BYTE_W;

  localparam logic [ADDR_W-1:0] A_CTRL      = 4'd0;
  localparam logic [ADDR_W-1:0] A_CLEAR     = 4'd1;
  localparam logic [ADDR_W-1:0] A_STATUS    = 4'd2;
  localparam logic [ADDR_W-1:0] A_INIT_BASE = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT_BASE  = 4'd7;

  typedef struct packed {
    logic [2:0] spare;
    logic       irq_en1;
    logic       irq_en0;
    logic       cascade;
    logic       run1;
    logic       run0;
  } ctrl_t;

  // A period ends when the value about to be decremented is 1 (or 0).
  function automatic logic period_done(input logic [63:0] value);
    return value < 64'd2;
  endfunction

  function automatic logic [2*CNT_W-1:0] step_down(input logic [2*CNT_W-1:0] value);
    return value - 1'b1;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] phase_q;

      assign tick = (phase_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
      end

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/count_core.sv
module count_core
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] init0,
  input  logic [CNT_W-1:0] init1,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1,
  output logic             expire0,
  output logic             expire1
);

  logic [2*CNT_W-1:0] joined, joined_init;
  logic               end0, end1;

  assign joined      = {cnt1, cnt0};
  assign joined_init = {init1, init0};
  assign end0    = ctrl.cascade ? period_done(64'(joined)) : period_done(64'(cnt0));
  assign end1    = period_done(64'(cnt1));
  assign expire0 = tick & ctrl.run0 & end0;
  assign expire1 = tick & ctrl.run1 & ~ctrl.cascade & end1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else if (ctrl.cascade) begin
      if (!ctrl.run0 || expire0) {cnt1, cnt0} <= joined_init;
      else if (tick)             {cnt1, cnt0} <= step_down(joined);
    end else begin
      if (!ctrl.run0 || expire0) cnt0 <= init0;
      else if (tick)             cnt0 <= cnt0 - 1'b1;
      if (!ctrl.run1 || expire1) cnt1 <= init1;
      else if (tick)             cnt1 <= cnt1 - 1'b1;
    end
  end

  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire0 && !ctrl.cascade) |=> cnt0 == $past(init0)); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl.run0 && !ctrl.cascade && !expire0) |=> cnt0 == $past(cnt0) - 1'b1); // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run0) |=> cnt0 == $past(init0)); // R3
  AST_UPPER_ON_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.cascade && ctrl.run0 && tick && cnt0 != '0 && !expire0) |=> $stable(cnt1)); // R4
  AST_CASCADE_ONE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.cascade |-> !expire1); // R4

endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              expire0,
  input  logic              expire1,
  input  logic [CNT_W-1:0]  cnt0,
  input  logic [CNT_W-1:0]  cnt1,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  init0,
  output logic [CNT_W-1:0]  init1,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] init_q [NBYTES];
  logic [1:0]        clr_mask, set_mask;
  logic              clr_write;

  assign clr_write = wr_en && (addr == A_CLEAR);
  assign clr_mask  = clr_write ? wdata[1:0] : 2'b00;
  assign set_mask  = {expire1, expire0};
  assign init0     = {init_q[1], init_q[0]};
  assign init1     = {init_q[3], init_q[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      status <= '0;
      for (int g = 0; g < NBYTES; g++) init_q[g] <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl <= ctrl_t'(wdata);
      for (int g = 0; g < NBYTES; g++)
        if (wr_en && addr == A_INIT_BASE + ADDR_W'(g)) init_q[g] <= wdata;
      status <= (status & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:          rdata = ctrl;
      A_STATUS:        rdata = {6'b0, status};
      A_INIT_BASE:     rdata = init_q[0];
      A_INIT_BASE + 1: rdata = init_q[1];
      A_INIT_BASE + 2: rdata = init_q[2];
      A_INIT_BASE + 3: rdata = init_q[3];
      A_CNT_BASE:      rdata = cnt0[7:0];
      A_CNT_BASE + 1:  rdata = cnt0[15:8];
      A_CNT_BASE + 2:  rdata = cnt1[7:0];
      A_CNT_BASE + 3:  rdata = cnt1[15:8];
      default:         rdata = '0;
    endcase
  end

  AST_SET_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire0 |=> status[0]); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_write && wdata[0] && !expire0) |=> !status[0]); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(clr_write && wdata[1])) |=> status[1]); // R6

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import timer_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 100_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq0,
  output logic              irq1
);

  localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic             tick, expire0, expire1;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] init0, init1, cnt0, cnt1;
  logic [1:0]       status;

  tick_prescaler #(.DIV(DIV)) i_prescaler (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  count_core i_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl),
    .init0(init0), .init1(init1), .cnt0(cnt0), .cnt1(cnt1),
    .expire0(expire0), .expire1(expire1)
  );

  timer_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire0(expire0), .expire1(expire1), .cnt0(cnt0), .cnt1(cnt1),
    .ctrl(ctrl), .init0(init0), .init1(init1), .status(status), .rdata(rdata)
  );

  assign irq0 = status[0] & ctrl.irq_en0;
  assign irq1 = status[1] & ctrl.irq_en1 & ~ctrl.cascade;

  AST_IRQ1_QUIET_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.cascade |-> !irq1); // R4
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> status[0]); // R7

endmodule

// File: tb/test_cascade_timer.sv
module test_cascade_timer;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst_n, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq0, irq1;
  int         checks = 0, errors = 0;
  bit         done = 0;

  cascade_timer #(.CLK_HZ(400_000), .TICK_HZ(100_000)) i_cascade_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq0(irq0), .irq1(irq1)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference model built from the requirements.
  int          m_phase;
  logic [7:0]  m_ctrl;
  logic [7:0]  m_init [4];
  logic [15:0] m_c0, m_c1;
  logic [1:0]  m_stat;
  logic [31:0] m_big, m_big_init;
  logic        m_tick, m_e0, m_e1;
  logic [1:0]  m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ctrl = 0; m_c0 = 0; m_c1 = 0; m_stat = 0;
      for (int i = 0; i < 4; i++) m_init[i] = 0;
    end else begin
      m_tick = (m_phase == DIV - 1);
      m_e0 = 0; m_e1 = 0;
      m_big_init = {m_init[3], m_init[2], m_init[1], m_init[0]};
      if (m_ctrl[2]) begin
        m_big = {m_c1, m_c0};
        if (!m_ctrl[0]) m_big = m_big_init;
        else if (m_tick) begin
          if (m_big <= 1) begin m_big = m_big_init; m_e0 = 1; end
          else m_big = m_big - 1;
        end
        m_c0 = m_big[15:0]; m_c1 = m_big[31:16];
      end else begin
        if (!m_ctrl[0]) m_c0 = {m_init[1], m_init[0]};
        else if (m_tick) begin
          if (m_c0 <= 1) begin m_c0 = {m_init[1], m_init[0]}; m_e0 = 1; end
          else m_c0 = m_c0 - 1;
        end
        if (!m_ctrl[1]) m_c1 = {m_init[3], m_init[2]};
        else if (m_tick) begin
          if (m_c1 <= 1) begin m_c1 = {m_init[3], m_init[2]}; m_e1 = 1; end
          else m_c1 = m_c1 - 1;
        end
      end
      m_clr  = (wr_en && addr == 4'd1) ? wdata[1:0] : 2'b00;
      m_stat = (m_stat & ~m_clr) | {m_e1, m_e0};
      if (wr_en && addr == 4'd0) m_ctrl = wdata;
      if (wr_en && addr >= 4'd3 && addr <= 4'd6) m_init[addr - 3] = wdata;
      m_phase = m_tick ? 0 : m_phase + 1;
    end
  end

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0:  return m_ctrl;
      4'd2:  return {6'b0, m_stat};
      4'd3, 4'd4, 4'd5, 4'd6: return m_init[a - 3];
      4'd7:  return m_c0[7:0];
      4'd8:  return m_c0[15:8];
      4'd9:  return m_c1[7:0];
      4'd10: return m_c1[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] a);
    if (a == 4'd2) return "R5";
    if (a >= 4'd7 && a <= 4'd10) return m_ctrl[2] ? "R4" : "R2";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk); wr_en = 0; addr = a; #1;
    check(tag, rdata, model_read(a));
  endtask

  // Interrupt levels against the model, away from the active edge.
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && !done) begin
      check("R7", irq0, m_stat[0] & m_ctrl[3]);
      check("R7", irq1, m_stat[1] & m_ctrl[4] & ~m_ctrl[2]);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] prev;
    int gap;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9: all-zero reset state
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); addr = 4'(a); #1;
      check("R9", rdata, 8'h00);
    end
    check("R9", {irq1, irq0}, 2'b00);

    // R3: stopped counter shows its initial value
    wr(4'd3, 8'h34); wr(4'd4, 8'h12);
    @(negedge clk); addr = 4'd7; #1; check("R3", rdata, 8'h34);
    @(negedge clk); addr = 4'd8; #1; check("R3", rdata, 8'h12);

    // R1: tick spacing measured on the live count
    wr(4'd3, 8'h03); wr(4'd4, 8'h00); wr(4'd0, 8'h01);
    @(negedge clk); addr = 4'd7; #1; prev = rdata;
    for (int k = 0; k < 20; k++) begin @(negedge clk); #1; if (rdata != prev) break; end
    prev = rdata; gap = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); #1; gap++; if (rdata != prev) break; end
    check("R1", gap, DIV);

    // R6: stop with zero control, status survives, interrupts drop
    wr(4'd0, 8'h09);
    repeat (3 * DIV) @(negedge clk);
    rd(4'd2, "R5");
    wr(4'd0, 8'h00);
    @(negedge clk); addr = 4'd2; #1; check("R6", rdata[0], 1'b1);
    check("R6", irq0, 1'b0);
    wr(4'd1, 8'h03);
    rd(4'd2, "R5");

    // R4: borrow from the low half into the high half
    wr(4'd3, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h01); wr(4'd6, 8'h00);
    rd(4'd9, "R4");
    wr(4'd0, 8'h05);
    repeat (2 * DIV) @(negedge clk);
    @(negedge clk); addr = 4'd7; #1; check("R4", rdata != 8'h00, 1'b1);
    check("R4", rdata, model_read(4'd7));
    rd(4'd9, "R4");
    wr(4'd0, 8'h00);

    // Constrained random mix
    for (int it = 0; it < 4000; it++) begin
      int sel = $urandom_range(0, 15);
      if (sel == 0) begin
        @(negedge clk); wr_en = 1; addr = 4'd0; wdata = 8'($urandom_range(0, 31));
      end else if (sel == 1) begin
        @(negedge clk); wr_en = 1; addr = 4'd1; wdata = 8'($urandom_range(0, 3));
      end else if (sel == 2) begin
        @(negedge clk); wr_en = 1; addr = 4'($urandom_range(3, 6));
        wdata = (addr == 4'd3 || addr == 4'd5) ? 8'($urandom_range(0, 12))
              : (($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 2)) : 8'h00);
      end else begin
        @(negedge clk); wr_en = 0; addr = 4'($urandom_range(0, 15)); #1;
        check(tag_for(addr), rdata, model_read(addr));
      end
    end
    @(negedge clk); wr_en = 0;
    for (int a = 0; a < 16; a++) rd(4'(a), tag_for(4'(a)));
    finish_run();
  end

endmodule